// File: doc/BRIEF.md
# CPU/GPU Way Partitioner with Hit-Count Scaling

This block decides how many ways of a shared set-associative cache go to a CPU application and how many go to a GPU application. For each application it takes one hit counter per recency position, ordered from most recently used to least recently used. The counters come from sampled shadow tag directories outside the block. The GPU counters are first divided by a normalisation ratio. That scaling compensates for the much higher access rate of a throughput-oriented GPU, whose raw hit counts would otherwise crowd the CPU out of the cache.

A start strobe captures the counters, the ratio and a cap flag. Each side begins with one way. The remaining ways are then handed out one per clock cycle. Each step compares the next-position hit count of the two sides and gives the way to the side that gains more. The cap flag is raised when GPU sampling finds that caching barely affects GPU performance. It zeroes the GPU utility, so the GPU keeps a single way and the CPU receives all the others. A one-cycle done pulse marks the final split, and the two way counts then hold until the next start.

Top module: `util_way_partitioner`

## Requirements
- R1: After reset, `done_o` is 0 and both way counts read 0.
- R2: When `start_i` is sampled high at a clock edge, `done_o` is high for exactly one cycle, beginning right after the (WAYS-2)th following edge. With WAYS=8 this is the sixth edge.
- R3: When `done_o` is high, `cpu_ways_o + gpu_ways_o` equals WAYS and each count is at least 1. Between the start edge and done, the total grows by exactly one per cycle.
- R4: Each step compares the CPU counter at position `cpu_ways_o` with the scaled GPU counter at position `gpu_ways_o`. Position 0 is MRU. The way goes to the larger one, and an equal pair goes to the CPU.
- R5: Each GPU counter is replaced by the truncated integer quotient counter / `ratio_i` before allocation. A ratio of 0 acts as a ratio of 1.
- R6: With `gpu_cap_i` high at the start edge, the result is 1 GPU way and WAYS-1 CPU ways, whatever the counters hold.
- R7: After `done_o`, the way counts stay unchanged and `done_o` stays low while `start_i` is low, even if the counter, ratio or cap inputs change.
- R8: A start strobe during an allocation abandons it and restarts from the newly presented inputs, with done timed from the new strobe.
- R9: Counter position p of either bus occupies bits [p*16 +: 16]. Inputs are only sampled at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture inputs and begin allocation |
| gpu_cap_i | input | 1 | Limit the GPU to one way |
| ratio_i | input | 8 | GPU hit-count divisor |
| cpu_hits_i | input | 128 | CPU hit counters, MRU at the lowest slice |
| gpu_hits_i | input | 128 | GPU hit counters, MRU at the lowest slice |
| done_o | output | 1 | One-cycle pulse when the split is final |
| cpu_ways_o | output | 4 | Ways given to the CPU |
| gpu_ways_o | output | 4 | Ways given to the GPU |

## Verification
The assertions assume that a start strobe is one cycle wide and that the counter inputs are meaningful only at the edge that samples it. They assume nothing about the counter values themselves. The cap check relies on the flag being captured together with the start. The bench drives every input on the falling edge and raises start for one cycle only. It changes the counter, ratio and cap inputs only between runs, except in the scenario that deliberately disturbs them after done. It deliberately restarts a run in flight.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    WP_IDLE = 1'b0,
    WP_RUN  = 1'b1
  } wp_state_e;
endpackage

// File: rtl/wp_scaler.sv
module wp_scaler #(
  parameter int WAYS    = 8,
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 8
) (
  input  logic [WAYS*CNT_W-1:0] raw_i,
  input  logic [RATIO_W-1:0]    ratio_i,
  input  logic                  cap_i,
  output logic [WAYS*CNT_W-1:0] scaled_o
);
  logic [CNT_W-1:0] divisor;

  always_comb begin
    divisor = {{(CNT_W-RATIO_W){1'b0}}, ratio_i};
    if (ratio_i == '0) divisor = CNT_W'(1);
  end

  for (genvar p = 0; p < WAYS; p++) begin : g_pos
    always_comb begin
      if (cap_i) scaled_o[p*CNT_W +: CNT_W] = '0;
      else       scaled_o[p*CNT_W +: CNT_W] = raw_i[p*CNT_W +: CNT_W] / divisor;
    end
  end
endmodule

// File: rtl/wp_chooser.sv
module wp_chooser #(
  parameter int WAYS  = 8,
  parameter int CNT_W = 16,
  localparam int IW   = (WAYS > 2) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*CNT_W-1:0] cpu_tab_i,
  input  logic [WAYS*CNT_W-1:0] gpu_tab_i,
  input  logic [IW-1:0]         cpu_pos_i,
  input  logic [IW-1:0]         gpu_pos_i,
  output logic                  give_cpu_o
);
  logic [CNT_W-1:0] cpu_next;
  logic [CNT_W-1:0] gpu_next;

  always_comb begin
    cpu_next   = cpu_tab_i[cpu_pos_i*CNT_W +: CNT_W];
    gpu_next   = gpu_tab_i[gpu_pos_i*CNT_W +: CNT_W];
    give_cpu_o = (cpu_next >= gpu_next);
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int SW  = (WAYS > 2) ? $clog2(WAYS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  localparam logic [SW-1:0] STEPS = SW'(WAYS - 2);

  wp_state_e state_q, state_d;
  logic [SW-1:0] rem_q, rem_d;
  logic done_q, done_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    if (start_i) begin
      load_o = 1'b1;
      if (STEPS == '0) begin
        state_d = WP_IDLE;
        done_d  = 1'b1;
      end else begin
        state_d = WP_RUN;
        rem_d   = STEPS;
      end
    end else if (state_q == WP_RUN) begin
      step_o = 1'b1;
      rem_d  = rem_q - 1'b1;
      if (rem_q == SW'(1)) begin
        state_d = WP_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WP_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/util_way_partitioner.sv
module util_way_partitioner #(
  parameter int WAYS    = 8,
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 8,
  localparam int CW     = $clog2(WAYS + 1),
  localparam int IW     = (WAYS > 2) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  gpu_cap_i,
  input  logic [RATIO_W-1:0]    ratio_i,
  input  logic [WAYS*CNT_W-1:0] cpu_hits_i,
  input  logic [WAYS*CNT_W-1:0] gpu_hits_i,
  output logic                  done_o,
  output logic [CW-1:0]         cpu_ways_o,
  output logic [CW-1:0]         gpu_ways_o
);
  logic [WAYS*CNT_W-1:0] gpu_scaled;
  logic [WAYS*CNT_W-1:0] cpu_tab_q, gpu_tab_q;
  logic [CW-1:0]         cpu_ways_q, cpu_ways_d;
  logic [CW-1:0]         gpu_ways_q, gpu_ways_d;
  logic load, step, give_cpu;

  wp_scaler #(.WAYS(WAYS), .CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_scaler (
    .raw_i    (gpu_hits_i),
    .ratio_i  (ratio_i),
    .cap_i    (gpu_cap_i),
    .scaled_o (gpu_scaled)
  );

  wp_ctrl #(.WAYS(WAYS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  wp_chooser #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chooser (
    .cpu_tab_i  (cpu_tab_q),
    .gpu_tab_i  (gpu_tab_q),
    .cpu_pos_i  (cpu_ways_q[IW-1:0]),
    .gpu_pos_i  (gpu_ways_q[IW-1:0]),
    .give_cpu_o (give_cpu)
  );

  // Counter snapshot, loaded only by the start strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_tab_q <= '0;
      gpu_tab_q <= '0;
    end else if (load) begin
      cpu_tab_q <= cpu_hits_i;
      gpu_tab_q <= gpu_scaled;
    end
  end

  always_comb begin
    cpu_ways_d = cpu_ways_q;
    gpu_ways_d = gpu_ways_q;
    if (load) begin
      cpu_ways_d = CW'(1);
      gpu_ways_d = CW'(1);
    end else if (step) begin
      if (give_cpu) cpu_ways_d = cpu_ways_q + 1'b1;
      else          gpu_ways_d = gpu_ways_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_ways_q <= '0;
      gpu_ways_q <= '0;
    end else if (load || step) begin
      cpu_ways_q <= cpu_ways_d;
      gpu_ways_q <= gpu_ways_d;
    end
  end

  assign cpu_ways_o = cpu_ways_q;
  assign gpu_ways_o = gpu_ways_q;
endmodule

// File: rtl/util_way_partitioner_chk.sv
module util_way_partitioner_chk #(
  parameter int WAYS    = 8,
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 8,
  localparam int CW     = $clog2(WAYS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          gpu_cap_i,
  input logic          done_o,
  input logic [CW-1:0] cpu_ways_o,
  input logic [CW-1:0] gpu_ways_o
);
  logic [CW:0] total;
  logic cap_q, settled_q;

  assign total = {1'b0, cpu_ways_o} + {1'b0, gpu_ways_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      if (start_i) cap_q <= gpu_cap_i;
      if (start_i)     settled_q <= 1'b0;
      else if (done_o) settled_q <= 1'b1;
    end
  end

  assert_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (total == (CW+1)'(WAYS)));

  assert_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cpu_ways_o != '0 && gpu_ways_o != '0));

  assert_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && total >= (CW+1)'(2) && total < (CW+1)'(WAYS)) |=> (total == $past(total) + 1'b1));

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_q) |-> (gpu_ways_o == CW'(1)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((settled_q || done_o) && !start_i) |=> ($stable(cpu_ways_o) && $stable(gpu_ways_o)));
endmodule

bind util_way_partitioner util_way_partitioner_chk #(
  .WAYS(WAYS), .CNT_W(CNT_W), .RATIO_W(RATIO_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .gpu_cap_i  (gpu_cap_i),
  .done_o     (done_o),
  .cpu_ways_o (cpu_ways_o),
  .gpu_ways_o (gpu_ways_o)
);

// File: tb/test_util_way_partitioner.sv
`timescale 1ns/1ps
module test_util_way_partitioner;
  localparam int W = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic gpu_cap_i = 1'b0;
  logic [7:0] ratio_i = 8'd1;
  logic [W*16-1:0] cpu_hits_i = '0;
  logic [W*16-1:0] gpu_hits_i = '0;
  logic done_o;
  logic [CW-1:0] cpu_ways_o, gpu_ways_o;

  int ch [W];
  int gh [W];
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  util_way_partitioner i_util_way_partitioner (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gpu_cap_i(gpu_cap_i),
    .ratio_i(ratio_i), .cpu_hits_i(cpu_hits_i), .gpu_hits_i(gpu_hits_i),
    .done_o(done_o), .cpu_ways_o(cpu_ways_o), .gpu_ways_o(gpu_ways_o)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference split built from the requirement text (R4, R5, R6)
  task automatic model(input int ratio, input bit cap, output int ec, output int eg);
    int d;
    int g [W];
    d = (ratio == 0) ? 1 : ratio;
    for (int p = 0; p < W; p++) g[p] = cap ? 0 : gh[p] / d;
    ec = 1; eg = 1;
    for (int s = 0; s < W - 2; s++) begin
      if (ch[ec] >= g[eg]) ec++;
      else eg++;
    end
  endtask

  task automatic present(input int ratio, input bit cap);
    for (int p = 0; p < W; p++) begin
      cpu_hits_i[p*16 +: 16] = 16'(ch[p]);
      gpu_hits_i[p*16 +: 16] = 16'(gh[p]);
    end
    ratio_i   = 8'(ratio);
    gpu_cap_i = cap;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Waits for done; returns the negedge count after the start strobe
  task automatic wait_done(output int n);
    n = 1;
    while (!done_o && n < 40) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic run_case(input string req, input int ratio, input bit cap);
    int ec, eg, n;
    present(ratio, cap);
    model(ratio, cap, ec, eg);
    pulse_start();
    wait_done(n);
    check({req, " done timing R2"}, n, W - 1);
    check({req, " cpu ways"}, int'(cpu_ways_o), ec);
    check({req, " gpu ways"}, int'(gpu_ways_o), eg);
    @(negedge clk);
    check({req, " done single cycle R2"}, int'(done_o), 0);
  endtask

  task automatic t_reset();
    check("R1 done", int'(done_o), 0);
    check("R1 cpu", int'(cpu_ways_o), 0);
    check("R1 gpu", int'(gpu_ways_o), 0);
  endtask

  task automatic t_gpu_dominant();
    ch = '{20, 3, 2, 1, 1, 0, 0, 0};
    gh = '{90, 80, 70, 60, 50, 40, 30, 20};
    run_case("R4 gpu dominant", 1, 1'b0);
    check("R4 gpu dominant split", int'(gpu_ways_o), 7);
  endtask

  task automatic t_cpu_dominant();
    ch = '{50, 40, 30, 20, 10, 9, 8, 7};
    gh = '{5, 4, 3, 2, 1, 1, 1, 1};
    run_case("R4 cpu dominant", 1, 1'b0);
    check("R4 cpu dominant split", int'(cpu_ways_o), 7);
  endtask

  task automatic t_mixed();
    ch = '{16, 3, 8, 20, 5, 8, 2, 1};
    gh = '{6, 11, 10, 18, 4, 9, 7, 3};
    run_case("R4 R9 mixed", 1, 1'b0);
  endtask

  task automatic t_ties();
    ch = '{5, 5, 5, 5, 5, 5, 5, 5};
    gh = '{5, 5, 5, 5, 5, 5, 5, 5};
    run_case("R4 ties", 1, 1'b0);
    check("R4 ties to cpu", int'(cpu_ways_o), 7);
  endtask

  task automatic t_ratio();
    ch = '{16, 3, 8, 20, 5, 8, 2, 1};
    gh = '{6, 11, 10, 18, 4, 9, 7, 3};
    run_case("R5 ratio 2", 2, 1'b0);
    ch = '{9, 9, 9, 9, 9, 9, 9, 9};
    gh = '{40, 39, 39, 39, 39, 39, 39, 39};
    run_case("R5 ratio 4 truncation", 4, 1'b0);
    check("R5 trunc split gpu", int'(gpu_ways_o), 1);
    run_case("R5 ratio 0", 0, 1'b0);
    check("R5 ratio 0 acts as 1", int'(gpu_ways_o), 7);
  endtask

  task automatic t_cap();
    ch = '{0, 0, 0, 0, 0, 0, 0, 0};
    gh = '{900, 800, 700, 600, 500, 400, 300, 200};
    run_case("R6 cap", 1, 1'b1);
    check("R6 gpu one way", int'(gpu_ways_o), 1);
    check("R6 cpu rest", int'(cpu_ways_o), W - 1);
  endtask

  task automatic t_hold();
    int c0, g0;
    c0 = int'(cpu_ways_o); g0 = int'(gpu_ways_o);
    ch = '{0, 99, 99, 99, 99, 99, 99, 99};
    gh = '{0, 0, 0, 0, 0, 0, 0, 0};
    present(1, 1'b0);
    repeat (6) @(negedge clk);
    check("R7 cpu held", int'(cpu_ways_o), c0);
    check("R7 gpu held", int'(gpu_ways_o), g0);
    check("R7 no done", int'(done_o), 0);
  endtask

  task automatic t_restart();
    int n, ec, eg;
    ch = '{1, 1, 1, 1, 1, 1, 1, 1};
    gh = '{90, 90, 90, 90, 90, 90, 90, 90};
    present(1, 1'b0);
    pulse_start();
    repeat (2) @(negedge clk);
    check("R8 no early done", int'(done_o), 0);
    ch = '{90, 90, 90, 90, 90, 90, 90, 90};
    gh = '{1, 1, 1, 1, 1, 1, 1, 1};
    present(1, 1'b0);
    model(1, 1'b0, ec, eg);
    pulse_start();
    wait_done(n);
    check("R8 done from new start", n, W - 1);
    check("R8 cpu from new inputs", int'(cpu_ways_o), ec);
    check("R8 gpu from new inputs", int'(gpu_ways_o), eg);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gpu_dominant();
    t_cpu_dominant();
    t_mixed();
    t_ties();
    t_ratio();
    t_cap();
    t_hold();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule